// File: doc/BRIEF.md
# Dual-Pipe FP Dispatch with Shared Overflow Queue

This block sits between the rename stage and two floating-point/vector issue pipes. Each pipe has a small out-of-order scheduler. A shared holding queue is strictly first-in-first-out and sits in front of both schedulers. It absorbs operations once their pipe's scheduler runs out of room. The holding queue never looks at operand readiness. It only hands its head operations to a scheduler that has a free slot. Because one pipe may fill only part of the holding queue, the other pipe always keeps some headroom.

Each cycle the upstream stage presents a group of up to five operations. Each operation carries a destination tag, a pipe select, and two source tags with ready bits. The block accepts the whole group or stalls it. Completing operations broadcast their destination tags on two wakeup ports. A matching broadcast marks the source ready wherever the operation is held. Each scheduler issues its oldest fully ready operation on a registered output. A flush input empties everything.

Top module: `fpq_dispatch`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after reset, both `iss_valid` bits are 0 and every queue is empty. `disp_stall` is 0 while no lane is valid.
- R2: Suppose a group is accepted at clock edge t. If an operation finds the holding queue empty after this edge's drain, and its pipe's scheduler has a free slot, it goes straight into that scheduler. If its sources are ready, it appears on `iss_valid`/`iss_tag` of its pipe after edge t+1. A scheduler slot counts as free if it was vacated by the issue at the same edge.
- R3: Each pipe issues at most one operation per cycle: the oldest operation in its scheduler whose two source-ready bits are both set. Age is the order of entry into the scheduler.
- R4: A wakeup lane with `wk_valid` high sets the ready bit of every source whose tag equals its tag. This applies to both schedulers, to the holding queue, and to operations accepted in the same cycle. An operation woken at edge t can issue at edge t+1.
- R5: An operation enters the holding queue only in two cases. Either its pipe's scheduler has no free slot left, or an older operation (in the queue, or an earlier lane of the same group) is already headed there.
- R6: The holding queue moves at most two operations per cycle from its head into the schedulers, strictly in order. It stops at the first head operation whose scheduler is full, whatever the readiness or pipe of the entries behind it. A scheduler never holds more than 16 operations.
- R7: Counts are taken before the cycle's drain. Call the number of valid lanes in the group n. The group is stalled (`disp_stall` high, nothing taken) when the holding-queue count plus n exceeds 23. It is also stalled when, for either pipe, that pipe's holding-queue entries plus its valid lanes exceed 18. No pipe ever has more than 18 holding-queue entries.
- R8: A flush at edge t empties both schedulers and the holding queue. It discards the group presented in that cycle, and both `iss_valid` bits are 0 after edge t.
- R9: Lane i of the group uses these fields:
  - `in_tag[6i+5:6i]` is the destination tag.
  - `in_pipe[i]` is the pipe (0 or 1).
  - Source s uses `in_src[12i+6s+5:12i+6s]` and `in_srdy[2i+s]`.
  - Lane 0 is the oldest operation of the group.
  - Wakeup lane w carries its tag on `wk_tag[6w+5:6w]`.
  - Issue pipe p reports on `iss_tag[6p+5:6p]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties all queues and drops the current group |
| in_valid | input | 5 | Valid bit per dispatch lane |
| in_tag | input | 30 | Destination tag per lane |
| in_pipe | input | 5 | Target pipe per lane |
| in_src | input | 60 | Two source tags per lane |
| in_srdy | input | 10 | Two source-ready bits per lane |
| wk_valid | input | 2 | Valid bit per wakeup lane |
| wk_tag | input | 12 | Broadcast tag per wakeup lane |
| disp_stall | output | 1 | Group cannot be accepted this cycle |
| iss_valid | output | 2 | Registered issue valid per pipe |
| iss_tag | output | 12 | Registered issued destination tag per pipe |

## Verification
The bound checker watches the capacity limits on every cycle: the per-pipe holding-queue cap, the holding-queue and scheduler depths, and a stall raised only for a present group. It also checks the quiet outputs that follow reset and flush.

Several properties depend on which tag comes out in which cycle, and only the bench's scenarios against its behavioural queue model can show them:
- oldest-ready selection;
- the bypass-versus-overflow choice;
- head-of-line blocking of a ready operation behind a stalled one;
- wakeups reaching held operations;
- the discarded group on flush.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
  localparam int TAG_W = 6;
  localparam int NSRC  = 2;
  localparam int NWAKE = 2;
  localparam int NPIPE = 2;

  typedef struct packed {
    logic [TAG_W-1:0]           tag;
    logic [NSRC-1:0][TAG_W-1:0] src;
    logic [NSRC-1:0]            rdy;
    logic                       pipe;
  } fp_op_t;

  // Mark sources matched by any valid broadcast as ready.
  function automatic fp_op_t wake(input fp_op_t e,
                                  input logic [NWAKE-1:0] v,
                                  input logic [NWAKE-1:0][TAG_W-1:0] t);
    fp_op_t r;
    r = e;
    for (int s = 0; s < NSRC; s++)
      for (int w = 0; w < NWAKE; w++)
        if (v[w] && (t[w] == e.src[s])) r.rdy[s] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/fpq_sched.sv
module fpq_sched
  import fpq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WR    = 7,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int WN   = $clog2(WR + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic [NWAKE-1:0]            wk_v,
  input  logic [NWAKE-1:0][TAG_W-1:0] wk_t,
  input  logic [WN-1:0]               wr_n,
  input  fp_op_t                      wr_op [WR],
  output logic [CW-1:0]               room,
  output logic [CW-1:0]               cnt_o,
  output logic                        iss_v,
  output logic [TAG_W-1:0]            iss_tag
);
  localparam int SW = $clog2(DEPTH);

  // Entries are kept compacted in age order: index 0 is the oldest.
  fp_op_t          ent [DEPTH];
  fp_op_t          nxt [DEPTH];
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   base;
  logic [DEPTH-1:0] rdy;
  logic            fire;
  logic [SW-1:0]   sel;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      rdy[i] = (i < int'(cnt)) && (&ent[i].rdy);
    fire = 1'b0;
    sel  = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (rdy[i]) begin
        fire = 1'b1;
        sel  = SW'(i);
      end
  end

  assign room  = CW'(DEPTH) - cnt + CW'(fire);
  assign cnt_o = cnt;

  always_comb begin
    base = cnt - CW'(fire);
    for (int i = 0; i < DEPTH; i++) begin
      if (fire && (i >= int'(sel)) && (i + 1 < DEPTH)) nxt[i] = ent[i + 1];
      else nxt[i] = ent[i];
    end
    for (int k = 0; k < WR; k++)
      if ((k < int'(wr_n)) && (int'(base) + k < DEPTH))
        nxt[int'(base) + k] = wr_op[k];
    for (int i = 0; i < DEPTH; i++)
      nxt[i] = wake(nxt[i], wk_v, wk_t);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt     <= '0;
      iss_v   <= 1'b0;
      iss_tag <= '0;
    end else begin
      cnt     <= base + CW'(wr_n);
      iss_v   <= fire;
      iss_tag <= ent[sel].tag;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) ent[i] <= nxt[i];
  end
endmodule

// File: rtl/fpq_hold.sv
module fpq_hold
  import fpq_pkg::*;
#(
  parameter int DEPTH = 23,
  parameter int WR    = 5,
  parameter int RD    = 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int WN   = $clog2(WR + 1),
  localparam int DN   = $clog2(RD + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic [NWAKE-1:0]             wk_v,
  input  logic [NWAKE-1:0][TAG_W-1:0]  wk_t,
  input  logic [DN-1:0]                drain_n,
  input  logic [WN-1:0]                push_n,
  input  fp_op_t                       push_op [WR],
  output fp_op_t                       head_op [RD],
  output logic [CW-1:0]                cnt_o,
  output logic [NPIPE-1:0][CW-1:0]     pcnt
);
  // In-order queue, head at index 0; readiness is carried but never examined.
  fp_op_t        ent [DEPTH];
  fp_op_t        nxt [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] base;

  assign cnt_o = cnt;

  always_comb begin
    for (int k = 0; k < RD; k++) head_op[k] = ent[k];
  end

  always_comb begin
    for (int p = 0; p < NPIPE; p++) begin
      int c;
      c = 0;
      for (int i = 0; i < DEPTH; i++)
        if ((i < int'(cnt)) && (ent[i].pipe == 1'(p))) c++;
      pcnt[p] = CW'(c);
    end
  end

  always_comb begin
    base = cnt - CW'(drain_n);
    for (int i = 0; i < DEPTH; i++) begin
      int j;
      j = i + int'(drain_n);
      if (j < DEPTH) nxt[i] = ent[j];
      else nxt[i] = ent[i];
    end
    for (int k = 0; k < WR; k++)
      if ((k < int'(push_n)) && (int'(base) + k < DEPTH))
        nxt[int'(base) + k] = push_op[k];
    for (int i = 0; i < DEPTH; i++)
      nxt[i] = wake(nxt[i], wk_v, wk_t);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) cnt <= '0;
    else cnt <= base + CW'(push_n);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) ent[i] <= nxt[i];
  end
endmodule

// File: rtl/fpq_dispatch.sv
module fpq_dispatch
  import fpq_pkg::*;
#(
  parameter int SQ_DEPTH = 16,
  parameter int HQ_DEPTH = 23,
  parameter int HQ_CAP   = 18,
  parameter int DW       = 5,
  parameter int NDRAIN   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush,
  input  logic [DW-1:0]             in_valid,
  input  logic [DW*TAG_W-1:0]       in_tag,
  input  logic [DW-1:0]             in_pipe,
  input  logic [DW*NSRC*TAG_W-1:0]  in_src,
  input  logic [DW*NSRC-1:0]        in_srdy,
  input  logic [NWAKE-1:0]          wk_valid,
  input  logic [NWAKE*TAG_W-1:0]    wk_tag,
  output logic                      disp_stall,
  output logic [NPIPE-1:0]          iss_valid,
  output logic [NPIPE*TAG_W-1:0]    iss_tag
);
  localparam int SQ_CW = $clog2(SQ_DEPTH + 1);
  localparam int HQ_CW = $clog2(HQ_DEPTH + 1);
  localparam int SWR   = NDRAIN + DW;
  localparam int SWN   = $clog2(SWR + 1);
  localparam int HWN   = $clog2(DW + 1);
  localparam int DN    = $clog2(NDRAIN + 1);

  logic [NWAKE-1:0][TAG_W-1:0] wk_tp;
  assign wk_tp = wk_tag;

  fp_op_t in_op [DW];
  always_comb begin
    for (int i = 0; i < DW; i++) begin
      in_op[i].tag  = in_tag[i*TAG_W +: TAG_W];
      in_op[i].pipe = in_pipe[i];
      for (int s = 0; s < NSRC; s++) begin
        in_op[i].src[s] = in_src[(i*NSRC + s)*TAG_W +: TAG_W];
        in_op[i].rdy[s] = in_srdy[i*NSRC + s];
      end
    end
  end

  fp_op_t                       hq_head [NDRAIN];
  logic [HQ_CW-1:0]             hq_cnt;
  logic [NPIPE-1:0][HQ_CW-1:0]  hq_pcnt;
  logic [NPIPE-1:0][SQ_CW-1:0]  room;
  logic [NPIPE-1:0][SQ_CW-1:0]  sq_cnt;

  fp_op_t           s_op [NPIPE][SWR];
  logic [SWN-1:0]   s_n  [NPIPE];
  fp_op_t           h_op [DW];
  logic [HWN-1:0]   h_n;
  logic [DN-1:0]    d_n;
  logic             fits;
  logic             accept;

  // Steering: drain the head in order first, then place the new group.
  always_comb begin
    int take [NPIPE];
    int sn   [NPIPE];
    int np   [NPIPE];
    int nv, dn, pn;
    logic stop, gone;
    for (int p = 0; p < NPIPE; p++) begin
      take[p] = 0;
      sn[p]   = 0;
      np[p]   = 0;
      for (int k = 0; k < SWR; k++) s_op[p][k] = '0;
    end
    for (int i = 0; i < DW; i++) h_op[i] = '0;
    nv = 0;
    for (int i = 0; i < DW; i++)
      if (in_valid[i]) begin
        nv++;
        np[in_pipe[i]]++;
      end
    fits = (int'(hq_cnt) + nv <= HQ_DEPTH);
    for (int p = 0; p < NPIPE; p++)
      if (int'(hq_pcnt[p]) + np[p] > HQ_CAP) fits = 1'b0;
    accept = fits && !flush;

    stop = 1'b0;
    dn   = 0;
    for (int k = 0; k < NDRAIN; k++) begin
      if (!stop && (k < int'(hq_cnt)) &&
          (take[hq_head[k].pipe] < int'(room[hq_head[k].pipe]))) begin
        s_op[hq_head[k].pipe][sn[hq_head[k].pipe]] = hq_head[k];
        sn[hq_head[k].pipe]++;
        take[hq_head[k].pipe]++;
        dn++;
      end else begin
        stop = 1'b1;
      end
    end

    gone = (int'(hq_cnt) != dn);
    pn   = 0;
    if (accept)
      for (int i = 0; i < DW; i++)
        if (in_valid[i]) begin
          if (!gone && (take[in_pipe[i]] < int'(room[in_pipe[i]]))) begin
            s_op[in_pipe[i]][sn[in_pipe[i]]] = in_op[i];
            sn[in_pipe[i]]++;
            take[in_pipe[i]]++;
          end else begin
            h_op[pn] = in_op[i];
            pn++;
            gone = 1'b1;
          end
        end
    for (int p = 0; p < NPIPE; p++) s_n[p] = SWN'(sn[p]);
    h_n = HWN'(pn);
    d_n = DN'(dn);
  end

  assign disp_stall = (|in_valid) && !fits;

  fpq_hold #(.DEPTH(HQ_DEPTH), .WR(DW), .RD(NDRAIN)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .wk_v    (wk_valid),
    .wk_t    (wk_tp),
    .drain_n (d_n),
    .push_n  (h_n),
    .push_op (h_op),
    .head_op (hq_head),
    .cnt_o   (hq_cnt),
    .pcnt    (hq_pcnt)
  );

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    logic [TAG_W-1:0] tag_p;
    fpq_sched #(.DEPTH(SQ_DEPTH), .WR(SWR)) u_sched (
      .clk     (clk),
      .rst     (rst),
      .flush   (flush),
      .wk_v    (wk_valid),
      .wk_t    (wk_tp),
      .wr_n    (s_n[p]),
      .wr_op   (s_op[p]),
      .room    (room[p]),
      .cnt_o   (sq_cnt[p]),
      .iss_v   (iss_valid[p]),
      .iss_tag (tag_p)
    );
    assign iss_tag[p*TAG_W +: TAG_W] = tag_p;
  end
endmodule

// File: rtl/fpq_dispatch_chk.sv
module fpq_dispatch_chk #(
  parameter int SQ_DEPTH = 16,
  parameter int HQ_DEPTH = 23,
  parameter int HQ_CAP   = 18,
  parameter int DW       = 5,
  localparam int SQ_CW   = $clog2(SQ_DEPTH + 1),
  localparam int HQ_CW   = $clog2(HQ_DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  flush,
  input logic [DW-1:0]         in_valid,
  input logic                  disp_stall,
  input logic [1:0]            iss_valid,
  input logic [HQ_CW-1:0]      hq_cnt,
  input logic [1:0][HQ_CW-1:0] hq_pcnt,
  input logic [1:0][SQ_CW-1:0] sq_cnt
);
  // R7
  hq_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(hq_pcnt[0]) <= HQ_CAP) && (int'(hq_pcnt[1]) <= HQ_CAP));

  // R7
  hq_fill_chk: assert property (@(posedge clk) disable iff (rst)
    int'(hq_cnt) <= HQ_DEPTH);

  // R6
  sq_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(sq_cnt[0]) <= SQ_DEPTH) && (int'(sq_cnt[1]) <= SQ_DEPTH));

  // R7
  stall_valid_chk: assert property (@(posedge clk) disable iff (rst)
    disp_stall |-> (|in_valid));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> ((iss_valid == 2'b00) && (hq_cnt == '0)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> ((iss_valid == 2'b00) && (hq_cnt == '0)));
endmodule

bind fpq_dispatch fpq_dispatch_chk #(
  .SQ_DEPTH(SQ_DEPTH), .HQ_DEPTH(HQ_DEPTH), .HQ_CAP(HQ_CAP), .DW(DW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .flush      (flush),
  .in_valid   (in_valid),
  .disp_stall (disp_stall),
  .iss_valid  (iss_valid),
  .hq_cnt     (hq_cnt),
  .hq_pcnt    (hq_pcnt),
  .sq_cnt     (sq_cnt)
);

// File: tb/tb_fpq_dispatch.sv
`timescale 1ns/1ps
module tb_fpq_dispatch;
  localparam int TW = 6;
  localparam int NL = 5;
  localparam int SQD = 16;
  localparam int HQD = 23;
  localparam int CAP = 18;

  logic clk = 0;
  logic rst = 1;
  logic flush = 0;
  logic [NL-1:0]      in_valid = '0;
  logic [NL*TW-1:0]   in_tag = '0;
  logic [NL-1:0]      in_pipe = '0;
  logic [NL*2*TW-1:0] in_src = '0;
  logic [NL*2-1:0]    in_srdy = '0;
  logic [1:0]         wk_valid = '0;
  logic [2*TW-1:0]    wk_tag = '0;
  logic               disp_stall;
  logic [1:0]         iss_valid;
  logic [2*TW-1:0]    iss_tag;

  fpq_dispatch dut (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_tag(in_tag),
    .in_pipe(in_pipe), .in_src(in_src), .in_srdy(in_srdy), .wk_valid(wk_valid),
    .wk_tag(wk_tag), .disp_stall(disp_stall), .iss_valid(iss_valid), .iss_tag(iss_tag)
  );

  always #10 clk = ~clk;

  typedef struct { int tag; int src[2]; bit rdy[2]; int pipe; } mop_t;
  mop_t sq [2][$];
  mop_t hq [$];
  bit   exp_v [2];
  int   exp_t [2];

  bit lv [NL];
  int ltag [NL], lpipe [NL];
  int lsrc [NL][2];
  bit lrdy [NL][2];
  bit wv [2];
  int wt [2];

  int nchk = 0, nerr = 0, tagctr = 0;
  string cur_req = "R1";
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, expv);
    end
  endtask

  task automatic clear_lanes();
    for (int i = 0; i < NL; i++) begin
      lv[i] = 0; ltag[i] = 0; lpipe[i] = 0;
      lsrc[i][0] = 0; lsrc[i][1] = 0; lrdy[i][0] = 0; lrdy[i][1] = 0;
    end
    wv[0] = 0; wv[1] = 0; wt[0] = 0; wt[1] = 0;
  endtask

  task automatic set_lane(input int i, input int pipe, input int s0, input bit r0,
                          input int s1, input bit r1);
    lv[i] = 1; ltag[i] = tagctr % 64; tagctr++; lpipe[i] = pipe;
    lsrc[i][0] = s0; lrdy[i][0] = r0; lsrc[i][1] = s1; lrdy[i][1] = r1;
  endtask

  task automatic pack();
    for (int i = 0; i < NL; i++) begin
      in_valid[i] = lv[i];
      in_tag[i*TW +: TW] = TW'(ltag[i]);
      in_pipe[i] = lpipe[i][0];
      for (int s = 0; s < 2; s++) begin
        in_src[(i*2+s)*TW +: TW] = TW'(lsrc[i][s]);
        in_srdy[i*2+s] = lrdy[i][s];
      end
    end
    for (int w = 0; w < 2; w++) begin
      wk_valid[w] = wv[w];
      wk_tag[w*TW +: TW] = TW'(wt[w]);
    end
  endtask

  function automatic bit model_fits();
    int nv, np [2], hp [2];
    nv = 0; np[0] = 0; np[1] = 0; hp[0] = 0; hp[1] = 0;
    for (int i = 0; i < NL; i++) if (lv[i]) begin nv++; np[lpipe[i]]++; end
    foreach (hq[j]) hp[hq[j].pipe]++;
    return (hq.size() + nv <= HQD) && (hp[0] + np[0] <= CAP) && (hp[1] + np[1] <= CAP);
  endfunction

  function automatic bit any_lane();
    for (int i = 0; i < NL; i++) if (lv[i]) return 1;
    return 0;
  endfunction

  task automatic model_step();
    bit f;
    int room [2];
    if (rst || flush) begin
      sq[0].delete(); sq[1].delete(); hq.delete();
      exp_v[0] = 0; exp_v[1] = 0;
      return;
    end
    f = model_fits();
    for (int p = 0; p < 2; p++) begin
      exp_v[p] = 0;
      for (int j = 0; j < sq[p].size(); j++)
        if (sq[p][j].rdy[0] && sq[p][j].rdy[1]) begin
          exp_v[p] = 1; exp_t[p] = sq[p][j].tag; sq[p].delete(j); break;
        end
      room[p] = SQD - sq[p].size();
    end
    for (int k = 0; k < 2; k++) begin
      if (hq.size() > 0 && room[hq[0].pipe] > 0) begin
        room[hq[0].pipe]--;
        sq[hq[0].pipe].push_back(hq[0]);
        void'(hq.pop_front());
      end else break;
    end
    if (f)
      for (int i = 0; i < NL; i++) if (lv[i]) begin
        mop_t m;
        m.tag = ltag[i]; m.pipe = lpipe[i];
        m.src[0] = lsrc[i][0]; m.src[1] = lsrc[i][1];
        m.rdy[0] = lrdy[i][0]; m.rdy[1] = lrdy[i][1];
        if (hq.size() == 0 && room[m.pipe] > 0) begin
          room[m.pipe]--; sq[m.pipe].push_back(m);
        end else hq.push_back(m);
      end
    for (int w = 0; w < 2; w++) if (wv[w]) begin
      for (int p = 0; p < 2; p++)
        for (int j = 0; j < sq[p].size(); j++)
          for (int s = 0; s < 2; s++) if (sq[p][j].src[s] == wt[w]) sq[p][j].rdy[s] = 1;
      for (int j = 0; j < hq.size(); j++)
        for (int s = 0; s < 2; s++) if (hq[j].src[s] == wt[w]) hq[j].rdy[s] = 1;
    end
  endtask

  // One clock: inputs set at the preceding falling edge.
  task automatic cycle();
    bit es;
    pack();
    #1;
    es = any_lane() && !model_fits();
    chk(disp_stall == es, "disp_stall", int'(disp_stall), int'(es));
    @(posedge clk);
    model_step();
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      chk(iss_valid[p] == exp_v[p], $sformatf("iss_valid[%0d]", p), int'(iss_valid[p]), int'(exp_v[p]));
      if (exp_v[p])
        chk(int'(iss_tag[p*TW +: TW]) == exp_t[p], $sformatf("iss_tag[%0d]", p),
            int'(iss_tag[p*TW +: TW]), exp_t[p]);
    end
  endtask

  task automatic idle(input int n);
    clear_lanes();
    for (int c = 0; c < n; c++) cycle();
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    clear_lanes();
    @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    rst = 1; idle(2);
    rst = 0; idle(2);

    // R2, R9: direct bypass, sparse lanes, both pipes
    cur_req = "R2,R9";
    clear_lanes();
    set_lane(0, 0, 1, 1, 2, 1);
    set_lane(1, 1, 3, 1, 4, 1);
    set_lane(4, 0, 5, 1, 6, 1);
    cycle(); idle(4);

    // R3, R4: oldest ready first, wakeup in both schedulers
    cur_req = "R3,R4";
    clear_lanes();
    set_lane(0, 0, 40, 0, 9, 1);
    set_lane(1, 0, 41, 0, 9, 1);
    set_lane(2, 0, 42, 0, 9, 1);
    set_lane(3, 1, 40, 0, 9, 1);
    cycle(); idle(2);
    clear_lanes(); wv[0] = 1; wt[0] = 42; cycle(); idle(2);
    clear_lanes(); wv[0] = 1; wt[0] = 41; wv[1] = 1; wt[1] = 40; cycle(); idle(4);

    // R5: fill pipe 0 scheduler, overflow into holding queue
    cur_req = "R5";
    for (int g = 0; g < 6; g++) begin
      clear_lanes();
      for (int i = 0; i < NL; i++) set_lane(i, 0, 50, 0, 9, 1);
      cycle();
    end
    clear_lanes();
    for (int i = 0; i < 4; i++) set_lane(i, 0, 50, 0, 9, 1);
    cycle();
    // R7: pipe 0 at its cap, pipe 1 keeps headroom, then queue full
    cur_req = "R7";
    clear_lanes(); set_lane(0, 0, 50, 0, 9, 1); cycle(); cycle();
    clear_lanes();
    for (int i = 0; i < NL; i++) set_lane(i, 1, 9, 1, 9, 1);
    cycle();
    clear_lanes(); set_lane(0, 1, 9, 1, 9, 1); cycle(); cycle();
    // R6, R4: ready pipe 1 ops wait behind pipe 0 head; wake reaches queue
    cur_req = "R6";
    idle(3);
    clear_lanes(); wv[1] = 1; wt[1] = 50; cycle();
    idle(60);

    // R8: flush drops state and the presented group
    cur_req = "R8";
    clear_lanes();
    for (int i = 0; i < NL; i++) set_lane(i, 1, 60, 0, 9, 1);
    cycle();
    clear_lanes(); set_lane(0, 0, 61, 1, 9, 1); flush = 1; cycle(); flush = 0;
    clear_lanes(); wv[0] = 1; wt[0] = 60; cycle(); idle(4);

    // Mixed random traffic against the model
    cur_req = "R3,R4,R5,R6,R7";
    for (int c = 0; c < 4000; c++) begin
      clear_lanes();
      for (int i = 0; i < NL; i++)
        if ($urandom_range(1, 0) == 1)
          set_lane(i, int'($urandom_range(1, 0)), int'($urandom_range(15, 0)),
                   bit'($urandom_range(1, 0)), int'($urandom_range(15, 0)),
                   bit'($urandom_range(1, 0)));
      for (int w = 0; w < 2; w++) begin
        wv[w] = bit'($urandom_range(1, 0));
        wt[w] = int'($urandom_range(15, 0));
      end
      flush = ($urandom_range(149, 0) == 0);
      cycle();
      flush = 0;
    end
    idle(10);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule